// File: doc/BRIEF.md
# DAC Code Sweep Sequencer

This block produces the digital stimulus for an exhaustive linearity test of a digital-to-analog converter. It holds an n-bit code and moves it up by one on each pulse of a code-rate strobe. It runs from zero to full scale and then starts again at zero. The code goes out on one bus that feeds both the converter under test and a reference converter. The code's top bit is brought out as a midscale marker, which a display can use to trigger. A single-cycle pulse marks the end of each full pass.

A coarse mode ties the four lowest code bits to zero on the output. The internal counter still steps through every value. The sweep therefore takes the same number of strobes, but each driven code is held for sixteen strobes, which gives the analog path longer to settle.

At every step a go/no-go window check looks at a signed, digitized error sample. The check waits a programmable number of clock cycles after the code changes, so that switching glitches are not judged. It then compares the sample against programmable upper and lower limits. The first code that falls outside the window is latched together with a sticky fail flag. A start request clears both and restarts the sweep from zero.

Top module: `dac_sweep_seq`

## Requirements
- R1: After synchronous reset, `dac_code` is 0, `mid_mark` is 0, `sweep_done` is 0 and `fail_flag` is 0.
- R2: Each clock edge that samples `tick` high, with `start` low, raises the internal count by exactly one. Without a tick or a start, the count and `dac_code` stay unchanged.
- R3: A tick taken at the final code (2^n − 1) returns the count to 0. In the cycle after that edge, `sweep_done` is 1 for exactly one cycle. It is 0 after every other step.
- R4: `mid_mark` equals bit n−1 (the MSB) of `dac_code` in both modes.
- R5: With `coarse` high, bits 3:0 of `dac_code` are 0 and bits n−1:4 follow the full-width count. A pass still takes 2^n ticks, so each driven code is held for 16 ticks.
- R6: The error sample is judged once per code step. The judging edge is the edge `settle_cycles`+1 edges after the edge that took the tick (or the start, or the release of reset). Sample values at any other time have no effect.
- R7: A sample fails when it is greater than `lim_hi` or less than `lim_lo`, with all three read as two's-complement signed values. A sample equal to either limit passes.
- R8: The first failure sets `fail_flag` and stores the `dac_code` value being driven, masked in coarse mode, in `fail_code`. Both hold through later failures and through sweep wraps.
- R9: `start` sets the count to 0 and clears `fail_flag` and `fail_code` on the same edge. It takes priority over a simultaneous tick, and no `sweep_done` follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart the sweep at zero and clear the fail record |
| tick | input | 1 | Code-rate strobe, one step per cycle high |
| coarse | input | 1 | 1 = drive the low four code bits as zero |
| settle_cycles | input | SETTLE_W | Clock cycles to wait after a code change before judging |
| err_sample | input | ERR_W | Signed digitized error sample |
| lim_hi | input | ERR_W | Signed upper window limit (inclusive) |
| lim_lo | input | ERR_W | Signed lower window limit (inclusive) |
| dac_code | output | CODE_W | Code driven to both converters |
| mid_mark | output | 1 | Code MSB, midscale/sync marker |
| sweep_done | output | 1 | One-cycle pulse after the wrap to zero |
| fail_flag | output | 1 | Sticky window failure flag |
| fail_code | output | CODE_W | First driven code that failed the window |

## Verification
The embedded properties check, on every cycle, the following rules. The count holds without a tick and steps by one with a tick. The end pulse coincides with a zero count and never lasts two cycles. The fail flag can only rise on a judging cycle and, once set, holds and keeps its stored code. A start always leaves a zero count and a clear flag. Other behaviour depends on the waveform of the error sample relative to the code changes, so only the bench's full and coarse sweeps can show it. This includes exclusion of the glitch interval, inclusive treatment of both limits, first-failure latching and the exact sequence of masked codes.

// File: rtl/dac_sweep_pkg.sv
package dac_sweep_pkg;

    localparam int COARSE_BITS = 4;
    localparam int JUDGE_W     = 32;

    typedef enum logic [1:0] {
        VERDICT_PASS = 2'd0,
        VERDICT_HIGH = 2'd1,
        VERDICT_LOW  = 2'd2
    } verdict_e;

    typedef struct packed {
        logic     fired;
        verdict_e verdict;
    } judge_result_t;

    function automatic verdict_e classify_window(
        input logic signed [JUDGE_W-1:0] sample,
        input logic signed [JUDGE_W-1:0] upper,
        input logic signed [JUDGE_W-1:0] lower
    );
        if (sample > upper)      return VERDICT_HIGH;
        else if (sample < lower) return VERDICT_LOW;
        else                     return VERDICT_PASS;
    endfunction

endpackage

// File: rtl/sweep_counter.sv
module sweep_counter #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    output logic [CODE_W-1:0] count,
    output logic              wrap_pulse
);
    logic [CODE_W-1:0] cnt_q;
    logic [CODE_W:0]   nxt;

    // The top bit of nxt acts as the terminal stage: it goes high only when
    // the low stages roll over.
    assign nxt = {1'b0, cnt_q} + {{CODE_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q      <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            wrap_pulse <= 1'b0;
            if (tick) begin
                if (nxt[CODE_W]) begin
                    cnt_q      <= '0;
                    wrap_pulse <= 1'b1;
                end else begin
                    cnt_q <= nxt[CODE_W-1:0];
                end
            end
        end
    end

    assign count = cnt_q;

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !start && (cnt_q != {CODE_W{1'b1}})) |=> (cnt_q == $past(cnt_q) + 1'b1));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start) |=> $stable(cnt_q));

endmodule

// File: rtl/code_shaper.sv
module code_shaper #(
    parameter int CODE_W    = 12,
    parameter int MASK_BITS = 4
) (
    input  logic [CODE_W-1:0] count,
    input  logic              coarse,
    output logic [CODE_W-1:0] code,
    output logic              msb_mark
);
    genvar b;
    generate
        for (b = 0; b < CODE_W; b++) begin : g_bit
            if (b < MASK_BITS) begin : g_gated
                assign code[b] = count[b] & ~coarse;
            end else begin : g_pass
                assign code[b] = count[b];
            end
        end
    endgenerate

    assign msb_mark = code[CODE_W-1];

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                judge
);
    logic [SETTLE_W-1:0] wait_q;
    logic                armed_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            wait_q  <= '0;
            armed_q <= 1'b1;
        end else if (armed_q) begin
            if (wait_q == settle_cycles) armed_q <= 1'b0;
            else                         wait_q  <= wait_q + 1'b1;
        end
    end

    assign judge = armed_q && (wait_q == settle_cycles) && !restart;

    a_r6_single_judge: assert property (@(posedge clk) disable iff (rst)
        (judge && !restart) |=> !judge);

endmodule

// File: rtl/window_judge.sv
module window_judge
    import dac_sweep_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int ERR_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    judge,
    input  logic signed [ERR_W-1:0] err_sample,
    input  logic signed [ERR_W-1:0] lim_hi,
    input  logic signed [ERR_W-1:0] lim_lo,
    input  logic [CODE_W-1:0]       code,
    output logic                    fail_flag,
    output logic [CODE_W-1:0]       fail_code
);
    localparam int EXT = JUDGE_W - ERR_W;

    logic signed [JUDGE_W-1:0] s_ext, h_ext, l_ext;
    judge_result_t             res;

    assign s_ext = {{EXT{err_sample[ERR_W-1]}}, err_sample};
    assign h_ext = {{EXT{lim_hi[ERR_W-1]}}, lim_hi};
    assign l_ext = {{EXT{lim_lo[ERR_W-1]}}, lim_lo};

    always_comb begin
        res.fired   = judge;
        res.verdict = classify_window(s_ext, h_ext, l_ext);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail_flag <= 1'b0;
            fail_code <= '0;
        end else if (res.fired && (res.verdict != VERDICT_PASS) && !fail_flag) begin
            fail_flag <= 1'b1;
            fail_code <= code;
        end
    end

    a_r6_fail_on_judge: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_flag) |-> $past(judge));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail_flag && !clear) |=> (fail_flag && $stable(fail_code)));

endmodule

// File: rtl/dac_sweep_seq.sv
module dac_sweep_seq
    import dac_sweep_pkg::*;
#(
    parameter int CODE_W   = 12,
    parameter int ERR_W    = 16,
    parameter int SETTLE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    tick,
    input  logic                    coarse,
    input  logic [SETTLE_W-1:0]     settle_cycles,
    input  logic signed [ERR_W-1:0] err_sample,
    input  logic signed [ERR_W-1:0] lim_hi,
    input  logic signed [ERR_W-1:0] lim_lo,
    output logic [CODE_W-1:0]       dac_code,
    output logic                    mid_mark,
    output logic                    sweep_done,
    output logic                    fail_flag,
    output logic [CODE_W-1:0]       fail_code
);
    logic [CODE_W-1:0] count;
    logic              judge;
    logic              restart;

    assign restart = start | tick;

    sweep_counter #(.CODE_W(CODE_W)) u_cnt (
        .clk(clk), .rst(rst), .start(start), .tick(tick),
        .count(count), .wrap_pulse(sweep_done)
    );

    code_shaper #(.CODE_W(CODE_W), .MASK_BITS(COARSE_BITS)) u_shape (
        .count(count), .coarse(coarse), .code(dac_code), .msb_mark(mid_mark)
    );

    settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk(clk), .rst(rst), .restart(restart),
        .settle_cycles(settle_cycles), .judge(judge)
    );

    window_judge #(.CODE_W(CODE_W), .ERR_W(ERR_W)) u_win (
        .clk(clk), .rst(rst), .clear(start), .judge(judge),
        .err_sample(err_sample), .lim_hi(lim_hi), .lim_lo(lim_lo),
        .code(dac_code), .fail_flag(fail_flag), .fail_code(fail_code)
    );

    a_r3_done_at_zero: assert property (@(posedge clk) disable iff (rst)
        sweep_done |-> (count == '0));

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        sweep_done |=> !sweep_done);

    a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> ((count == '0) && !fail_flag && !sweep_done));

endmodule

// File: tb/dac_sweep_seq_tb_top.sv
module dac_sweep_seq_tb_top;
    localparam int CW = 8;
    localparam int EW = 12;
    localparam int SW = 4;
    localparam int S  = 3;
    localparam int HI = 100;
    localparam int LO = -100;
    localparam int BAD = 500;
    localparam int NCODES = 1 << CW;

    logic clk = 1'b0;
    logic rst, start, tick, coarse;
    logic [SW-1:0] settle_cycles;
    logic signed [EW-1:0] err_sample, lim_hi, lim_lo;
    logic [CW-1:0] dac_code, fail_code;
    logic mid_mark, sweep_done, fail_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    dac_sweep_seq #(.CODE_W(CW), .ERR_W(EW), .SETTLE_W(SW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .tick(tick), .coarse(coarse),
        .settle_cycles(settle_cycles), .err_sample(err_sample),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .dac_code(dac_code),
        .mid_mark(mid_mark), .sweep_done(sweep_done),
        .fail_flag(fail_flag), .fail_code(fail_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One code step: tick, then a glitchy (bad) sample for S cycles, then
    // the settled value held across the judging edge.
    task automatic step(input int settled, output int code_o, output int done_o,
                        output int mid_o, output int done_next);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        code_o = int'(dac_code);
        done_o = int'(sweep_done);
        mid_o  = int'(mid_mark);
        err_sample = EW'(BAD);
        @(negedge clk) done_next = int'(sweep_done);
        repeat (S - 1) @(negedge clk);
        err_sample = EW'(settled);
        repeat (3) @(negedge clk);
        err_sample = '0;
    endtask

    function automatic int settled_for(input int c);
        if (c == 'h20) return HI;        // R7 upper limit inclusive
        if (c == 'h10) return LO;        // R7 lower limit inclusive
        if (c == 'h37) return HI + 1;    // R7 first failure
        if (c == 'h50) return LO - 1;    // R8 later failure, must not overwrite
        return 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c, d, m, dn, p, nx, dones;
        rst = 1'b1; start = 1'b0; tick = 1'b0; coarse = 1'b0;
        settle_cycles = SW'(S); err_sample = '0;
        lim_hi = EW'(HI); lim_lo = EW'(LO);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dac_code == 0, "R1 code", int'(dac_code), 0);
        check(mid_mark == 0, "R1 mid", int'(mid_mark), 0);
        check(sweep_done == 0, "R1 done", int'(sweep_done), 0);
        check(fail_flag == 0, "R1 fail", int'(fail_flag), 0);
        repeat (20) @(negedge clk);
        check(dac_code == 0, "R2 hold without tick", int'(dac_code), 0);

        // Full-mode sweep over every code.
        p = 0; dones = 0;
        for (int i = 0; i < NCODES; i++) begin
            nx = (p + 1) % NCODES;
            step(settled_for(nx), c, d, m, dn);
            check(c == nx, "R2 code step", c, nx);
            check(d == ((p == NCODES - 1) ? 1 : 0), "R3 done pulse", d, (p == NCODES - 1) ? 1 : 0);
            check(dn == 0, "R3 done one cycle", dn, 0);
            check(m == ((nx >> (CW - 1)) & 1), "R4 mid mark", m, (nx >> (CW - 1)) & 1);
            if (nx == 'h36) check(fail_flag == 0, "R6 glitch ignored", int'(fail_flag), 0);
            dones += d;
            p = nx;
        end
        check(dones == 1, "R3 one done per pass", dones, 1);
        check(fail_flag == 1, "R7 fail flag", int'(fail_flag), 1);
        check(fail_code == 'h37, "R8 first code kept", int'(fail_code), 'h37);

        // Start with a simultaneous tick.
        @(negedge clk) begin start = 1'b1; tick = 1'b1; end
        @(negedge clk) begin start = 1'b0; tick = 1'b0; end
        check(dac_code == 0, "R9 start zeroes", int'(dac_code), 0);
        check(fail_flag == 0, "R9 start clears flag", int'(fail_flag), 0);
        check(fail_code == 0, "R9 start clears code", int'(fail_code), 0);
        check(sweep_done == 0, "R9 no done", int'(sweep_done), 0);
        repeat (8) @(negedge clk);
        for (int i = 1; i <= 5; i++) begin
            step((i == 5) ? LO - 1 : 0, c, d, m, dn);
            check(c == i, "R2 code after start", c, i);
        end
        check(fail_flag == 1, "R7 below lower limit", int'(fail_flag), 1);
        check(fail_code == 5, "R8 latched code", int'(fail_code), 5);

        // Coarse-mode sweep.
        @(negedge clk) begin start = 1'b1; coarse = 1'b1; end
        @(negedge clk) start = 1'b0;
        repeat (8) @(negedge clk);
        p = 0; dones = 0;
        for (int i = 0; i < NCODES; i++) begin
            nx = (p + 1) % NCODES;
            step(0, c, d, m, dn);
            check(c == (nx & 'hF0), "R5 coarse code", c, nx & 'hF0);
            check(d == ((p == NCODES - 1) ? 1 : 0), "R5 coarse pass length", d, (p == NCODES - 1) ? 1 : 0);
            check(m == ((nx >> (CW - 1)) & 1), "R4 mid mark coarse", m, (nx >> (CW - 1)) & 1);
            dones += d;
            p = nx;
        end
        check(dones == 1, "R5 one done per coarse pass", dones, 1);
        check(fail_flag == 0, "R6 coarse glitches ignored", int'(fail_flag), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule